// File: doc/BRIEF.md
# Overlay Window Fetch Address Generator

This block serves one overlay window of a display engine. It takes the window's framebuffer layout (base byte address, whole-line width in pixels including padding, and a source offset in pixels and lines), the window's inclusive on-screen corners, and a pixel format code. When the line index and a one-cycle `line_start_i` pulse arrive, it turns them into a train of read bursts, counted in 32-bit words, that covers exactly the window's width on that line.

The block also flags whether the current screen position lies inside the enabled window. It reports whether the format asks the blender to use the per-pixel alpha channel. The maximum burst size depends on the buffer's line width. Wide buffers use 16-word bursts. Buffers narrower than a threshold use 8-word bursts, because long bursts on small buffers cause tearing. The last burst of every line is trimmed so that no read runs past the window's last pixel.

Top module: `win_fetch_gen`

## Requirements
- R1: The first burst of line n has byte address base + ((off_y + n) * stride + off_x) * bytes_per_pixel. All parameters are sampled in the cycle where `line_start_i` is high.
- R2: Format code 0 (16-bit 5-6-5) uses 2 bytes per pixel. Every format code 1 to 15 uses 4 bytes per pixel.
- R3: When the stride is 128 pixels or more, each burst except the last of a line is 16 words long.
- R4: When the stride is below 128 pixels, each burst except the last of a line is 8 words long.
- R5: Bursts appear on consecutive cycles, starting the cycle after `line_start_i` is sampled. Each burst's address is the previous address plus 4 times the previous length.
- R6: Per line, the burst lengths sum to ceil((br_x - tl_x + 1) * bytes_per_pixel / 4). The final burst carries the remainder. `req_vld_o` drops on the cycle after the final burst.
- R7: One cycle after the screen position is presented, `hit_o` is high exactly when `win_en_i` is high and tl_x <= scr_x <= br_x and tl_y <= scr_y <= br_y.
- R8: `blend_o` is high for format codes 5 to 15 (formats with alpha) and low for codes 0 to 4.
- R9: A `line_start_i` pulse during a burst train abandons the remaining bursts. The new line's first burst follows on the next cycle.
- R10: While reset is held, `req_vld_o` and `hit_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_en_i | input | 1 | Window enable |
| fmt_i | input | 4 | Pixel format code |
| base_addr_i | input | ADDR_W | Framebuffer base byte address |
| stride_i | input | COORD_W | Whole-line width in pixels, padding included |
| off_x_i | input | COORD_W | Source x offset in pixels |
| off_y_i | input | COORD_W | Source y offset in lines |
| tl_x_i | input | COORD_W | Window left column, inclusive |
| tl_y_i | input | COORD_W | Window top row, inclusive |
| br_x_i | input | COORD_W | Window right column, inclusive |
| br_y_i | input | COORD_W | Window bottom row, inclusive |
| line_start_i | input | 1 | Start burst train for one line |
| line_idx_i | input | COORD_W | Line index within the window |
| scr_x_i | input | COORD_W | Current screen column |
| scr_y_i | input | COORD_W | Current screen row |
| req_vld_o | output | 1 | Burst request valid |
| req_addr_o | output | ADDR_W | Burst byte address |
| req_len_o | output | 5 | Burst length in words |
| blend_o | output | 1 | Per-pixel alpha blending requested |
| hit_o | output | 1 | Screen position inside enabled window |

## Verification
The assertions take for granted that br_x is not left of tl_x and that the computed line address fits in the address width. They also assume `line_start_i` is a single-cycle pulse, except when it deliberately restarts a line. The stimulus keeps every window well formed and stays small enough that no address wraps. It holds the layout inputs steady between the start pulse and the end of the line, apart from the one restart case. The hit checks place the screen position at each corner, one step outside each edge, and inside with the window disabled.

// File: rtl/wfa_pkg.sv
`timescale 1ns/1ps
package wfa_pkg;
  localparam int FMT_W = 4;

  typedef struct packed {
    logic wide4;
    logic alpha;
  } fmt_info_t;

  // code 0: 16-bit 565; 1..4: opaque 32-bit; 5..15: 32-bit with alpha
  function automatic fmt_info_t decode_fmt(input logic [FMT_W-1:0] code);
    fmt_info_t f;
    f.wide4 = (code != '0);
    f.alpha = (code >= FMT_W'(5));
    return f;
  endfunction
endpackage

// File: rtl/wfa_fmt_decode.sv
`timescale 1ns/1ps
module wfa_fmt_decode
  import wfa_pkg::*;
(
  input  logic [FMT_W-1:0] fmt_i,
  output logic             bpp4_o,
  output logic             alpha_o
);
  fmt_info_t info;
  always_comb begin
    info    = decode_fmt(fmt_i);
    bpp4_o  = info.wide4;
    alpha_o = info.alpha;
  end
endmodule

// File: rtl/wfa_hit_detect.sv
`timescale 1ns/1ps
module wfa_hit_detect #(
  parameter int COORD_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [COORD_W-1:0] scr_x_i,
  input  logic [COORD_W-1:0] scr_y_i,
  input  logic [COORD_W-1:0] tl_x_i,
  input  logic [COORD_W-1:0] tl_y_i,
  input  logic [COORD_W-1:0] br_x_i,
  input  logic [COORD_W-1:0] br_y_i,
  output logic               hit_o
);
  logic in_x, in_y;
  assign in_x = (scr_x_i >= tl_x_i) && (scr_x_i <= br_x_i);
  assign in_y = (scr_y_i >= tl_y_i) && (scr_y_i <= br_y_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= 1'b0;
    else         hit_o <= en_i && in_x && in_y;
  end

  p_hit_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !hit_o);
  p_hit_outside_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scr_x_i > br_x_i) |=> !hit_o);
endmodule

// File: rtl/wfa_burst_seq.sv
`timescale 1ns/1ps
module wfa_burst_seq #(
  parameter int ADDR_W       = 32,
  parameter int CNT_W        = 13,
  parameter int BURST_WIDE   = 16,
  parameter int BURST_NARROW = 8,
  parameter int LEN_W        = $clog2(BURST_WIDE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  words_i,
  input  logic              narrow_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);
  logic              busy_q, narrow_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  max_c, len_c;

  assign max_c = narrow_q ? CNT_W'(BURST_NARROW) : CNT_W'(BURST_WIDE);
  assign len_c = (left_q < max_c) ? left_q : max_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      narrow_q <= 1'b0;
      addr_q   <= '0;
      left_q   <= '0;
    end else if (start_i) begin
      busy_q   <= (words_i != '0);
      narrow_q <= narrow_i;
      addr_q   <= addr_i;
      left_q   <= words_i;
    end else if (busy_q) begin
      addr_q <= addr_q + ADDR_W'({len_c, 2'b00});
      left_q <= left_q - len_c;
      busy_q <= (left_q != len_c);
    end
  end

  assign vld_o  = busy_q;
  assign addr_o = addr_q;
  assign len_o  = LEN_W'(len_c);

  p_len_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (len_o != '0) && (len_o <= LEN_W'(BURST_WIDE)));
  p_narrow_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && narrow_i) |=> (!vld_o || len_o <= LEN_W'(BURST_NARROW)));
  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !start_i) |=> (!vld_o || addr_o == $past(addr_o) + ADDR_W'({$past(len_o), 2'b00})));
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && words_i != '0) |=> (vld_o && addr_o == $past(addr_i)));
endmodule

// File: rtl/win_fetch_gen.sv
`timescale 1ns/1ps
module win_fetch_gen
  import wfa_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int COORD_W      = 12,
  parameter int BURST_WIDE   = 16,
  parameter int BURST_NARROW = 8,
  parameter int STRIDE_MIN   = 128,
  parameter int LEN_W        = $clog2(BURST_WIDE + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               win_en_i,
  input  logic [FMT_W-1:0]   fmt_i,
  input  logic [ADDR_W-1:0]  base_addr_i,
  input  logic [COORD_W-1:0] stride_i,
  input  logic [COORD_W-1:0] off_x_i,
  input  logic [COORD_W-1:0] off_y_i,
  input  logic [COORD_W-1:0] tl_x_i,
  input  logic [COORD_W-1:0] tl_y_i,
  input  logic [COORD_W-1:0] br_x_i,
  input  logic [COORD_W-1:0] br_y_i,
  input  logic               line_start_i,
  input  logic [COORD_W-1:0] line_idx_i,
  input  logic [COORD_W-1:0] scr_x_i,
  input  logic [COORD_W-1:0] scr_y_i,
  output logic               req_vld_o,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [LEN_W-1:0]   req_len_o,
  output logic               blend_o,
  output logic               hit_o
);
  localparam int CNT_W  = COORD_W + 1;
  localparam int PROD_W = 2 * COORD_W + 1;
  localparam int OFF_W  = PROD_W + 2;

  logic              bpp4;
  logic [CNT_W-1:0]  row, win_w, words;
  logic [PROD_W-1:0] pix;
  logic [OFF_W-1:0]  byte_off;
  logic [ADDR_W-1:0] line_addr;
  logic              narrow;

  wfa_fmt_decode u_fmt (
    .fmt_i   (fmt_i),
    .bpp4_o  (bpp4),
    .alpha_o (blend_o)
  );

  always_comb begin
    row       = {1'b0, off_y_i} + {1'b0, line_idx_i};
    pix       = PROD_W'(row) * PROD_W'(stride_i) + PROD_W'(off_x_i);
    byte_off  = bpp4 ? {pix, 2'b00} : {1'b0, pix, 1'b0};
    line_addr = base_addr_i + ADDR_W'(byte_off);
    win_w     = {1'b0, br_x_i} - {1'b0, tl_x_i} + CNT_W'(1);
    words     = bpp4 ? win_w : ((win_w + CNT_W'(1)) >> 1);
    narrow    = (stride_i < COORD_W'(STRIDE_MIN));
  end

  wfa_burst_seq #(
    .ADDR_W       (ADDR_W),
    .CNT_W        (CNT_W),
    .BURST_WIDE   (BURST_WIDE),
    .BURST_NARROW (BURST_NARROW),
    .LEN_W        (LEN_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (line_start_i),
    .addr_i   (line_addr),
    .words_i  (words),
    .narrow_i (narrow),
    .vld_o    (req_vld_o),
    .addr_o   (req_addr_o),
    .len_o    (req_len_o)
  );

  wfa_hit_detect #(.COORD_W(COORD_W)) u_hit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (win_en_i),
    .scr_x_i (scr_x_i),
    .scr_y_i (scr_y_i),
    .tl_x_i  (tl_x_i),
    .tl_y_i  (tl_y_i),
    .br_x_i  (br_x_i),
    .br_y_i  (br_y_i),
    .hit_o   (hit_o)
  );

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (!req_vld_o && !hit_o));
endmodule

// File: tb/win_fetch_gen_tb.sv
`timescale 1ns/1ps
module win_fetch_gen_tb;
  logic        clk = 0, rst_n = 0;
  logic        win_en = 0, line_start = 0;
  logic [3:0]  fmt = 0;
  logic [31:0] base = 0;
  logic [11:0] stride = 0, off_x = 0, off_y = 0, tl_x = 0, tl_y = 0, br_x = 0, br_y = 0;
  logic [11:0] line_idx = 0, scr_x = 0, scr_y = 0;
  logic        req_vld, blend, hit;
  logic [31:0] req_addr;
  logic [4:0]  req_len;

  int checks = 0, fails = 0;
  logic [36:0] exp_q[$];   // {addr, len}
  bit done = 0;

  always #10 clk = ~clk;

  win_fetch_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .win_en_i(win_en), .fmt_i(fmt), .base_addr_i(base),
    .stride_i(stride), .off_x_i(off_x), .off_y_i(off_y), .tl_x_i(tl_x), .tl_y_i(tl_y),
    .br_x_i(br_x), .br_y_i(br_y), .line_start_i(line_start), .line_idx_i(line_idx),
    .scr_x_i(scr_x), .scr_y_i(scr_y), .req_vld_o(req_vld), .req_addr_o(req_addr),
    .req_len_o(req_len), .blend_o(blend), .hit_o(hit));

  // expected bursts from current inputs, per R1..R6
  task automatic push_exp(input bit only_first);
    longint bpp, a, words, maxb, l;
    bpp   = (fmt == 0) ? 2 : 4;
    a     = longint'(base) + ((longint'(off_y) + line_idx) * stride + off_x) * bpp;
    words = ((longint'(br_x) - tl_x + 1) * bpp + 3) / 4;
    maxb  = (stride < 128) ? 8 : 16;
    while (words > 0) begin
      l = (words < maxb) ? words : maxb;
      exp_q.push_back({a[31:0], l[4:0]});
      a += 4 * l;
      words -= l;
      if (only_first) break;
    end
  endtask

  // monitor: samples 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk); #5;
      if (rst_n && req_vld) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R6: unexpected burst addr=%h len=%0d, expected none", req_addr, req_len);
        end else begin
          logic [36:0] e;
          e = exp_q.pop_front();
          if ({req_addr, req_len} !== e) begin
            fails++;
            $display("FAIL R1/R5: burst addr=%h len=%0d, expected addr=%h len=%0d",
                     req_addr, req_len, e[36:5], e[4:0]);
          end
        end
      end
    end
  end

  task automatic set_layout(input logic [3:0] f, input int s, input int ox, input int oy,
                            input int tx, input int bx, input int n, input logic [31:0] b);
    fmt = f; stride = 12'(s); off_x = 12'(ox); off_y = 12'(oy);
    tl_x = 12'(tx); br_x = 12'(bx); line_idx = 12'(n); base = b;
  endtask

  task automatic run_line(input string tag);
    @(negedge clk);
    push_exp(0);
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || req_vld) begin
      fails++;
      $display("FAIL %s: line end pending=%0d vld=%b, expected 0 and 0", tag, exp_q.size(), req_vld);
    end
  endtask

  task automatic chk_hit(input int x, input int y, input bit e, input string tag);
    @(negedge clk);
    scr_x = 12'(x); scr_y = 12'(y);
    @(posedge clk); #5;
    checks++;
    if (hit !== e) begin
      fails++;
      $display("FAIL %s: hit at (%0d,%0d) = %b, expected %b", tag, x, y, hit, e);
    end
  endtask

  task automatic chk_blend(input logic [3:0] code, input bit e);
    @(negedge clk);
    fmt = code;
    #1;
    checks++;
    if (blend !== e) begin
      fails++;
      $display("FAIL R8: blend for code %0d = %b, expected %b", code, blend, e);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R10
    if (req_vld !== 1'b0 || hit !== 1'b0) begin
      fails++;
      $display("FAIL R10: in reset vld=%b hit=%b, expected 0 0", req_vld, hit);
    end
    rst_n = 1;
    win_en = 1;
    repeat (2) @(negedge clk);

    // R1 R3 R6: 4 B/px, 40 px wide, stride 200 -> 16,16,8
    set_layout(4'd1, 200, 3, 5, 10, 49, 2, 32'h1000_0000);
    run_line("R3");
    // R2 R4: 565, 37 px -> 19 words, stride 100 -> 8,8,3
    set_layout(4'd0, 100, 7, 1, 0, 36, 4, 32'h2000_0000);
    run_line("R4");
    // R3 boundary: stride 128 is wide, 16 words -> one burst
    set_layout(4'd6, 128, 0, 0, 100, 115, 1, 32'h0000_4000);
    run_line("R3");
    // R4 boundary: stride 127 is narrow, 16 words -> 8,8
    set_layout(4'd2, 127, 1, 0, 100, 115, 3, 32'h0000_8000);
    run_line("R4");
    // R6: single 565 pixel at odd offset -> 1 word
    set_layout(4'd0, 300, 5, 2, 9, 9, 0, 32'h0001_0000);
    run_line("R6");
    // R2: 565 wide stride, 64 px -> 32 words -> 16,16
    set_layout(4'd0, 640, 0, 0, 0, 63, 10, 32'h0002_0000);
    run_line("R2");

    // R9: restart mid-train
    set_layout(4'd1, 400, 0, 0, 0, 99, 0, 32'h0003_0000);
    @(negedge clk);
    push_exp(1);
    line_start = 1;
    @(negedge clk);
    set_layout(4'd3, 90, 2, 2, 0, 19, 1, 32'h0004_0000);
    push_exp(0);
    @(negedge clk);
    line_start = 0;
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || req_vld) begin
      fails++;
      $display("FAIL R9: after restart pending=%0d vld=%b, expected 0 and 0", exp_q.size(), req_vld);
    end

    // R7 hit detection
    tl_x = 12'd20; br_x = 12'd40; tl_y = 12'd10; br_y = 12'd30;
    chk_hit(20, 10, 1, "R7");
    chk_hit(40, 30, 1, "R7");
    chk_hit(30, 20, 1, "R7");
    chk_hit(19, 20, 0, "R7");
    chk_hit(41, 20, 0, "R7");
    chk_hit(30, 9, 0, "R7");
    chk_hit(30, 31, 0, "R7");
    @(negedge clk); win_en = 0;
    chk_hit(30, 20, 0, "R7");
    @(negedge clk); win_en = 1;
    chk_hit(30, 20, 1, "R7");

    // R8 blend decode
    chk_blend(4'd0, 0);
    chk_blend(4'd4, 0);
    chk_blend(4'd5, 1);
    chk_blend(4'd8, 1);
    chk_blend(4'd15, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule